// File: doc/BRIEF.md
# Serial Configuration Port with Chip-Select Wake

This block is a write-only three-wire serial port that configures a mixed-signal front end. A host lowers the active-low select line and clocks in a 16-bit command word, most significant bit first, on rising serial-clock edges. The top four bits of the word name a register and the lower twelve carry its data. The word is applied only when select returns high, and only if exactly sixteen bits were clocked in. All three serial pins are brought into the system clock domain through synchronizers. Edges are found from the synchronized samples, so the serial clock may rest at either level between frames.

The port holds five settings: the operating mode, a wake-up mode select, a transmit offset, a common-mode level and an auxiliary-converter word. Writing the shutdown code to the mode register puts the front end to sleep. While asleep the port watches the select line alone. Any low-then-high pulse on select wakes it into the mode held in the wake-up select register, and any bits clocked during that pulse are thrown away. The other settings keep the values they had before shutdown. Each accepted update, including a wake, produces a one-cycle strobe carrying the register address, so downstream logic can apply the new value.

Top module: `cfg_wake_port`

## Requirements
- R1: After reset the mode is shutdown (code 1), the wake-up select is idle (code 2), offset is 0x800, common-mode is 0x400, the auxiliary word is 0x000, and `asleep_o` is high.
- R2: A frame starts when select falls. Bits are taken MSB first on rising serial-clock edges. Word bits [15:12] are the address and bits [11:0] are the data. The register changes only after select rises.
- R3: A frame that ends with a bit count other than 16 (fewer or more) changes no register and gives no strobe.
- R4: The address map is 1 mode (data[2:0]), 2 wake-up select (data[2:0]), 3 offset, 4 common-mode, 5 auxiliary. Frames to address 0 or 6 to 15 are dropped without a strobe.
- R5: The mode codes are 1 shutdown, 2 idle, 3 standby, 4 receive, 5 transmit, 6 full duplex and 7 loopback. A mode write of code 0 is ignored, and the mode output never shows 0.
- R6: A wake-up select write of code 0 or 1 is ignored, so the stored wake-up select is always between 2 and 7.
- R7: While the mode is shutdown, clocked frames update no register. A select pulse that ends while asleep moves the mode to the stored wake-up select value.
- R8: On wake, offset, common-mode, auxiliary and wake-up select keep the values they had before shutdown.
- R9: Each accepted update, including a wake, gives `wr_strobe_o` high for exactly one cycle with `wr_addr_o` equal to the register address (1 for a wake). A register output changes only in a cycle that strobes its address.
- R10: Frames are accepted both when the serial clock rests low and when it rests high between frames.
- R11: Writing mode code 1 puts the block into shutdown, and `asleep_o` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select and wake line (asynchronous) |
| sclk | input | 1 | Serial clock (asynchronous) |
| din | input | 1 | Serial data (asynchronous) |
| mode_o | output | 3 | Current operating mode code |
| wake_sel_o | output | 3 | Mode entered on wake |
| offset_o | output | 12 | Transmit offset setting |
| cm_o | output | 12 | Common-mode setting |
| aux_o | output | 12 | Auxiliary converter setting |
| asleep_o | output | 1 | High while in shutdown |
| wr_strobe_o | output | 1 | One-cycle pulse per accepted update |
| wr_addr_o | output | 4 | Address of the update being strobed |

## Verification
The hardest case to reach is a complete, well-formed 16-bit frame sent while the port is asleep. Sent while awake, the same frame would be applied. Sent while asleep, it must only wake the port, with the wake-up select chosen earlier, and leave every data register untouched. To reach it, the stimulus first writes a non-default wake-up select, changes the offset, puts the port to sleep through a normal mode write, and then sends a real offset command. The checks confirm that the mode comes from the wake-up select, that the offset keeps its pre-sleep value, and that the only strobe carries address 1.

// File: rtl/cfg_wake_pkg.sv
package cfg_wake_pkg;

    localparam int unsigned MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_RSVD     = 3'd0,
        MODE_SHUTDOWN = 3'd1,
        MODE_IDLE     = 3'd2,
        MODE_STANDBY  = 3'd3,
        MODE_RX       = 3'd4,
        MODE_TX       = 3'd5,
        MODE_FDX      = 3'd6,
        MODE_LOOP     = 3'd7
    } mode_e;

    localparam int unsigned REG_MODE    = 1;
    localparam int unsigned REG_WAKESEL = 2;
    localparam int unsigned REG_OFFSET  = 3;
    localparam int unsigned REG_CMV     = 4;
    localparam int unsigned REG_AUX     = 5;

endpackage

// File: rtl/cfg_wake_sync.sv
module cfg_wake_sync #(
    parameter int unsigned       W      = 3,
    parameter int unsigned       STAGES = 2,
    parameter logic [W-1:0]      RST    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_q[g] <= RST;
            end else if (g == 0) begin
                stg_q[g] <= d;
            end else begin
                stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/cfg_wake_shifter.sv
module cfg_wake_shifter #(
    parameter int unsigned FRAME_BITS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n_s,
    input  logic                  sclk_s,
    input  logic                  din_s,
    input  logic                  asleep,
    output logic                  frame_done,
    output logic                  frame_ok,
    output logic [FRAME_BITS-1:0] frame_word
);
    localparam int unsigned CNT_MAX = FRAME_BITS + 1;
    localparam int unsigned CNT_W   = $clog2(FRAME_BITS + 2);

    typedef struct packed {
        logic                  cs_p;
        logic                  sclk_p;
        logic [FRAME_BITS-1:0] sh;
        logic [CNT_W-1:0]      cnt;
    } shf_t;

    shf_t st_d, st_q;
    logic cs_fall, cs_rise, sclk_rise;

    always_comb begin
        st_d      = st_q;
        cs_fall   = st_q.cs_p & ~cs_n_s;
        cs_rise   = ~st_q.cs_p & cs_n_s;
        sclk_rise = ~st_q.sclk_p & sclk_s;
        st_d.cs_p   = cs_n_s;
        st_d.sclk_p = sclk_s;
        if (cs_fall) begin
            st_d.sh  = '0;
            st_d.cnt = '0;
        end else if (!cs_n_s && sclk_rise && !asleep) begin
            st_d.sh = {st_q.sh[FRAME_BITS-2:0], din_s};
            if (st_q.cnt != CNT_W'(CNT_MAX)) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        frame_done = cs_rise;
        // R3: only an exact 16-bit count qualifies; R7: nothing qualifies while asleep
        frame_ok   = cs_rise && !asleep && (st_q.cnt == CNT_W'(FRAME_BITS));
        frame_word = st_q.sh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cs_p: 1'b1, sclk_p: 1'b0, sh: '0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/cfg_wake_regs.sv
module cfg_wake_regs
    import cfg_wake_pkg::*;
#(
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned DATA_W     = 12,
    parameter int unsigned OFFSET_RST = 'h800,
    parameter int unsigned CMV_RST    = 'h400,
    parameter int unsigned AUX_RST    = 'h000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_done,
    input  logic                     frame_ok,
    input  logic [ADDR_W+DATA_W-1:0] frame_word,
    output logic [MODE_W-1:0]        mode,
    output logic [MODE_W-1:0]        wake_sel,
    output logic [DATA_W-1:0]        offset,
    output logic [DATA_W-1:0]        cmv,
    output logic [DATA_W-1:0]        aux,
    output logic                     asleep,
    output logic                     stb,
    output logic [ADDR_W-1:0]        stb_addr
);
    typedef struct packed {
        mode_e             mode;
        mode_e             wsel;
        logic [DATA_W-1:0] offs;
        logic [DATA_W-1:0] cmv;
        logic [DATA_W-1:0] aux;
        logic              stb;
        logic [ADDR_W-1:0] stb_addr;
    } regs_t;

    regs_t rg_d, rg_q;
    logic [ADDR_W-1:0] w_addr;
    logic [DATA_W-1:0] w_data;
    mode_e             w_code;

    always_comb begin
        rg_d     = rg_q;
        rg_d.stb = 1'b0;
        w_addr   = frame_word[ADDR_W+DATA_W-1:DATA_W];
        w_data   = frame_word[DATA_W-1:0];
        w_code   = mode_e'(w_data[MODE_W-1:0]);
        if (frame_done && rg_q.mode == MODE_SHUTDOWN) begin
            // R7/R8: a select pulse while asleep wakes into the preselected mode only
            rg_d.mode     = rg_q.wsel;
            rg_d.stb      = 1'b1;
            rg_d.stb_addr = ADDR_W'(REG_MODE);
        end else if (frame_ok) begin
            if (w_addr == ADDR_W'(REG_MODE)) begin
                if (w_code != MODE_RSVD) begin          // R5
                    rg_d.mode     = w_code;
                    rg_d.stb      = 1'b1;
                    rg_d.stb_addr = w_addr;
                end
            end else if (w_addr == ADDR_W'(REG_WAKESEL)) begin
                if (w_code != MODE_RSVD && w_code != MODE_SHUTDOWN) begin  // R6
                    rg_d.wsel     = w_code;
                    rg_d.stb      = 1'b1;
                    rg_d.stb_addr = w_addr;
                end
            end else if (w_addr == ADDR_W'(REG_OFFSET)) begin
                rg_d.offs     = w_data;
                rg_d.stb      = 1'b1;
                rg_d.stb_addr = w_addr;
            end else if (w_addr == ADDR_W'(REG_CMV)) begin
                rg_d.cmv      = w_data;
                rg_d.stb      = 1'b1;
                rg_d.stb_addr = w_addr;
            end else if (w_addr == ADDR_W'(REG_AUX)) begin
                rg_d.aux      = w_data;
                rg_d.stb      = 1'b1;
                rg_d.stb_addr = w_addr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '{mode: MODE_SHUTDOWN, wsel: MODE_IDLE,
                      offs: DATA_W'(OFFSET_RST), cmv: DATA_W'(CMV_RST),
                      aux: DATA_W'(AUX_RST), stb: 1'b0, stb_addr: '0};
        end else begin
            rg_q <= rg_d;
        end
    end

    assign mode     = rg_q.mode;
    assign wake_sel = rg_q.wsel;
    assign offset   = rg_q.offs;
    assign cmv      = rg_q.cmv;
    assign aux      = rg_q.aux;
    assign asleep   = (rg_q.mode == MODE_SHUTDOWN);
    assign stb      = rg_q.stb;
    assign stb_addr = rg_q.stb_addr;
endmodule

// File: rtl/cfg_wake_port.sv
module cfg_wake_port
    import cfg_wake_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned DATA_W      = 12,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned OFFSET_RST  = 'h800,
    parameter int unsigned CMV_RST     = 'h400,
    parameter int unsigned AUX_RST     = 'h000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    output logic [2:0]        mode_o,
    output logic [2:0]        wake_sel_o,
    output logic [DATA_W-1:0] offset_o,
    output logic [DATA_W-1:0] cm_o,
    output logic [DATA_W-1:0] aux_o,
    output logic              asleep_o,
    output logic              wr_strobe_o,
    output logic [ADDR_W-1:0] wr_addr_o
);
    localparam int unsigned FRAME_BITS = ADDR_W + DATA_W;

    logic [2:0]            pins_s;
    logic                  f_done, f_ok, asleep;
    logic [FRAME_BITS-1:0] f_word;

    // bit 2 select (rests high), bit 1 serial clock, bit 0 data
    cfg_wake_sync #(.W(3), .STAGES(SYNC_STAGES), .RST(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sclk, din}),
        .q     (pins_s)
    );

    cfg_wake_shifter #(.FRAME_BITS(FRAME_BITS)) u_shf (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_s     (pins_s[2]),
        .sclk_s     (pins_s[1]),
        .din_s      (pins_s[0]),
        .asleep     (asleep),
        .frame_done (f_done),
        .frame_ok   (f_ok),
        .frame_word (f_word)
    );

    cfg_wake_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .OFFSET_RST(OFFSET_RST), .CMV_RST(CMV_RST), .AUX_RST(AUX_RST)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (f_done),
        .frame_ok   (f_ok),
        .frame_word (f_word),
        .mode       (mode_o),
        .wake_sel   (wake_sel_o),
        .offset     (offset_o),
        .cmv        (cm_o),
        .aux        (aux_o),
        .asleep     (asleep),
        .stb        (wr_strobe_o),
        .stb_addr   (wr_addr_o)
    );

    assign asleep_o = asleep;
endmodule

// File: rtl/cfg_wake_chk.sv
module cfg_wake_chk #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        mode_o,
    input logic [2:0]        wake_sel_o,
    input logic [DATA_W-1:0] offset_o,
    input logic [DATA_W-1:0] cm_o,
    input logic [DATA_W-1:0] aux_o,
    input logic              asleep_o,
    input logic              wr_strobe_o,
    input logic [ADDR_W-1:0] wr_addr_o
);
    assert_mode_never_rsvd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 3'd0);

    assert_wake_sel_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_sel_o >= 3'd2);

    assert_frozen_while_asleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        asleep_o |=> ($stable(offset_o) && $stable(cm_o) && $stable(aux_o) && $stable(wake_sel_o)));

    assert_wake_uses_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
        asleep_o |=> (asleep_o || mode_o == $past(wake_sel_o)));

    assert_strobe_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe_o |=> !wr_strobe_o);

    assert_offset_change_strobed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (offset_o != $past(offset_o)) |-> (wr_strobe_o && wr_addr_o == ADDR_W'(3)));

    assert_mode_change_strobed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != $past(mode_o)) |-> (wr_strobe_o && wr_addr_o == ADDR_W'(1)));
endmodule

bind cfg_wake_port cfg_wake_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_o      (mode_o),
    .wake_sel_o  (wake_sel_o),
    .offset_o    (offset_o),
    .cm_o        (cm_o),
    .aux_o       (aux_o),
    .asleep_o    (asleep_o),
    .wr_strobe_o (wr_strobe_o),
    .wr_addr_o   (wr_addr_o)
);

// File: tb/cfg_wake_port_tb.sv
module cfg_wake_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CS_IDLE    = 12;   // > 80 ns of select-high gap

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic [2:0]  mode_o, wake_sel_o;
    logic [11:0] offset_o, cm_o, aux_o;
    logic        asleep_o, wr_strobe_o;
    logic [3:0]  wr_addr_o;

    int checks = 0;
    int fails  = 0;
    int stb_cnt = 0;
    int stb_dbl = 0;
    logic [3:0] stb_last = '0;
    logic stb_prev = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_wake_port u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .mode_o(mode_o), .wake_sel_o(wake_sel_o), .offset_o(offset_o),
        .cm_o(cm_o), .aux_o(aux_o), .asleep_o(asleep_o),
        .wr_strobe_o(wr_strobe_o), .wr_addr_o(wr_addr_o)
    );

    always @(negedge clk) begin
        if (wr_strobe_o) begin
            stb_cnt++;
            stb_last = wr_addr_o;
            if (stb_prev) stb_dbl++;
        end
        stb_prev = wr_strobe_o;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [31:0] w, input int n, input bit idle_hi);
        sclk = idle_hi;
        clks(2);
        cs_n = 1'b0;
        clks(4);
        for (int i = n - 1; i >= 0; i--) begin
            din = w[i];
            if (idle_hi) begin
                sclk = 1'b0; clks(3); sclk = 1'b1; clks(3);
            end else begin
                clks(3); sclk = 1'b1; clks(3); sclk = 1'b0;
            end
        end
        clks(3);
        cs_n = 1'b1;
        clks(CS_IDLE);
    endtask

    task automatic t_reset();
        chk("R1 mode", mode_o, 3'd1);
        chk("R1 wake_sel", wake_sel_o, 3'd2);
        chk("R1 offset", offset_o, 12'h800);
        chk("R1 cm", cm_o, 12'h400);
        chk("R1 aux", aux_o, 12'h000);
        chk("R1 asleep", asleep_o, 1'b1);
    endtask

    task automatic t_first_wake();
        int s0 = stb_cnt;
        send({4'd3, 12'h123}, 16, 1'b0);   // full frame while asleep
        chk("R7 woke to idle", mode_o, 3'd2);
        chk("R7 offset untouched", offset_o, 12'h800);
        chk("R9 wake strobe count", stb_cnt - s0, 1);
        chk("R9 wake strobe addr", stb_last, 4'd1);
    endtask

    task automatic t_writes();
        int s0 = stb_cnt;
        send({4'd3, 12'h3A5}, 16, 1'b0);
        chk("R2 offset", offset_o, 12'h3A5);
        chk("R9 offset strobe addr", stb_last, 4'd3);
        send({4'd4, 12'h7F0}, 16, 1'b1);
        chk("R10 cm idle-high clock", cm_o, 12'h7F0);
        send({4'd5, 12'hC3C}, 16, 1'b1);
        chk("R10 aux idle-high clock", aux_o, 12'hC3C);
        chk("R9 three strobes", stb_cnt - s0, 3);
    endtask

    task automatic t_bad_length();
        int s0 = stb_cnt;
        send({4'd5, 12'h111} >> 1, 15, 1'b0);
        chk("R3 short frame aux", aux_o, 12'hC3C);
        send({4'd5, 12'h222, 1'b1}, 17, 1'b1);
        chk("R3 long frame aux", aux_o, 12'hC3C);
        chk("R3 no strobe", stb_cnt - s0, 0);
    endtask

    task automatic t_unknown();
        int s0 = stb_cnt;
        send({4'd0, 12'h001}, 16, 1'b0);
        send({4'd9, 12'h555}, 16, 1'b0);
        chk("R4 offset kept", offset_o, 12'h3A5);
        chk("R4 cm kept", cm_o, 12'h7F0);
        chk("R4 mode kept", mode_o, 3'd2);
        chk("R4 no strobe", stb_cnt - s0, 0);
    endtask

    task automatic t_modes();
        int s0 = stb_cnt;
        send({4'd1, 12'h000}, 16, 1'b0);
        chk("R5 reserved mode ignored", mode_o, 3'd2);
        send({4'd1, 12'h004}, 16, 1'b0);
        chk("R5 mode rx", mode_o, 3'd4);
        send({4'd2, 12'h001}, 16, 1'b0);
        chk("R6 wake_sel shutdown ignored", wake_sel_o, 3'd2);
        send({4'd2, 12'h000}, 16, 1'b0);
        chk("R6 wake_sel zero ignored", wake_sel_o, 3'd2);
        send({4'd2, 12'h005}, 16, 1'b0);
        chk("R6 wake_sel tx", wake_sel_o, 3'd5);
        chk("R9 mode/select strobes", stb_cnt - s0, 2);
    endtask

    task automatic t_sleep_wake();
        int s0;
        send({4'd1, 12'h001}, 16, 1'b0);
        chk("R11 asleep", asleep_o, 1'b1);
        chk("R11 mode shutdown", mode_o, 3'd1);
        s0 = stb_cnt;
        send({4'd3, 12'hFFF}, 16, 1'b1);   // real command, must only wake
        chk("R7 woke to tx", mode_o, 3'd5);
        chk("R7 awake", asleep_o, 1'b0);
        chk("R8 offset kept", offset_o, 12'h3A5);
        chk("R8 cm kept", cm_o, 12'h7F0);
        chk("R8 aux kept", aux_o, 12'hC3C);
        chk("R8 wake_sel kept", wake_sel_o, 3'd5);
        chk("R9 single wake strobe", stb_cnt - s0, 1);
        chk("R9 wake addr", stb_last, 4'd1);
    endtask

    initial begin
        clks(4);
        rst_n = 1'b1;
        clks(4);
        t_reset();
        t_first_wake();
        t_writes();
        t_bad_length();
        t_unknown();
        t_modes();
        t_sleep_wake();
        chk("R9 strobe never two cycles", stb_dbl, 0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule